// File: doc/BRIEF.md
# Keyed configuration item access port

This block gives a host processor read access to a set of small numbered configuration items, each a byte array with its own length. The host writes a 16-bit key to the selector address. That picks the item and sets a byte cursor back to zero. Each access at the data address then moves through the item in ascending byte order. An access may be 1, 2, 4 or 8 bytes wide. Bytes that lie past the end of the item read as zero.

Two bits of the key are not part of the index. One bit marks an architecture-specific item instead of a generic one. The other bit opens the selected item to data writes. Generic key 0 always holds a fixed four-byte signature, so the host can tell that the device is there. Generic key 1 holds a feature word. Item contents and lengths are elaboration parameters. They are reloaded into on-chip storage on every reset.

Top module: `cfgkey_port`

## Requirements
- R1: Reset leaves key 0x0000 selected with the cursor at zero. The signature can therefore be read with no selector write, and contents changed by earlier data writes are restored to their parameter values.
- R2: A write at address 0 loads bus_wdata[15:0] as the key and sets the cursor to zero. The bus_size input is ignored for this write.
- R3: A read at address 1 returns the byte at the cursor in bits 7:0, then the following bytes in ascending lanes. The width is 1, 2, 4 or 8 bytes for bus_size codes 0, 1, 2 and 3. Lanes above the width read as zero, and bus_rdata is zero whenever no data read is in progress.
- R4: Every read or write at address 1 advances the cursor by the access width. This includes ignored writes. The cursor saturates at its all-ones value and never wraps.
- R5: A byte whose position is at or beyond the item length reads as 0x00. In an access that crosses the end, the bytes still inside the item are returned normally.
- R6: Key bit 15 set selects the architecture-specific set and bit 15 clear selects the generic set. Bits 13:0 are the index. Generic index i uses slot i, and architecture index j uses slot N_GEN+j. An index past the count of its set behaves as an item of length zero.
- R7: While key bit 14 is clear, data writes change no stored byte.
- R8: While key bit 14 is set, a data write stores lane k at cursor+k for each lane inside both the width and the item length. Lanes outside those limits are dropped.
- R9: Generic key 0 holds a 4-byte item that reads as 0x43, 0x46, 0x47, 0x4B in ascending order. It is read-only whatever bit 14 says.
- R10: Generic key 1 holds a 4-byte little-endian feature word. Bit 0 is always 1, bit 1 equals DMA_PRESENT, and every other bit is 0. It is read-only.
- R11: A read at address 0 returns zero and leaves the cursor unchanged.
- R12: Each other slot s holds byte SEED xor (s*ITEM_BYTES + offset), truncated to 8 bits. Its length is ITEM_LEN[8s+7:8s], limited to ITEM_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 = selector, 1 = data |
| bus_wr | input | 1 | Write strobe; takes precedence over bus_rd |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access width code: 0/1/2/3 = 1/2/4/8 bytes |
| bus_wdata | input | 64 | Write data; lane 0 is bits 7:0 |
| bus_rdata | output | 64 | Read data, valid in the cycle of the read strobe |

## Verification
The bench builds the block with its default geometry of four generic slots, two architecture slots and 16 bytes per slot. It sets DMA_PRESENT to 1, so feature bit 1 is driven high. The default lengths of 16, 5, 7 and 0 give a full-length item, a 5-byte item that an 8-byte read crosses, and an empty item. With only two architecture slots, architecture index 2 is an unpopulated key. The 16-byte slot size keeps the cursor at six bits, so nine 8-byte reads push it into saturation. The bench checks there that the cursor does not wrap back to data.

// File: rtl/cfgk_pkg.sv
package cfgk_pkg;

    typedef enum logic [1:0] {
        SZ_1 = 2'd0,
        SZ_2 = 2'd1,
        SZ_4 = 2'd2,
        SZ_8 = 2'd3
    } acc_size_e;

    // key layout: bit 15 architecture set, bit 14 write open, 13:0 index
    typedef struct packed {
        logic        arch;
        logic        wr_open;
        logic [13:0] idx;
    } sel_key_t;

    localparam int LANES       = 8;
    localparam int FIXED_ITEMS = 2;
    localparam int FIXED_LEN   = 4;
    localparam logic [31:0] SIG_WORD = 32'h4B47_4643;

    function automatic logic [3:0] size_bytes(input acc_size_e s);
        return 4'd1 << s;
    endfunction

    function automatic logic [7:0] fill_byte(input logic [7:0] seed, input int slot,
                                             input int off, input int item_bytes);
        return seed ^ 8'(slot * item_bytes + off);
    endfunction

    function automatic logic [7:0] fixed_byte(input int slot, input int off, input logic dma);
        if (off >= FIXED_LEN) return 8'h00;
        if (slot == 0) return SIG_WORD[off*8 +: 8];
        return (off == 0) ? {6'b0, dma, 1'b1} : 8'h00;
    endfunction

endpackage

// File: rtl/cfgk_keydec.sv
module cfgk_keydec
    import cfgk_pkg::*;
#(
    parameter int N_GEN      = 4,
    parameter int N_ARCH     = 2,
    parameter int ITEM_BYTES = 16,
    parameter int SLOTS      = 6,
    parameter int SLOT_W     = 3,
    parameter int OFF_W      = 6,
    parameter logic [SLOTS*8-1:0] ITEM_LEN = '0
) (
    input  sel_key_t          key,
    output logic [SLOT_W-1:0] slot,
    output logic [OFF_W-1:0]  len,
    output logic              wr_ok
);
    logic present;
    logic fixed;
    int   raw_len;

    always_comb begin
        present = key.arch ? (int'(key.idx) < N_ARCH) : (int'(key.idx) < N_GEN);
        fixed   = !key.arch && (int'(key.idx) < FIXED_ITEMS);
        slot    = '0;
        raw_len = 0;
        if (present) begin
            slot    = key.arch ? SLOT_W'(N_GEN + int'(key.idx)) : SLOT_W'(key.idx);
            raw_len = fixed ? FIXED_LEN : int'(ITEM_LEN[slot*8 +: 8]);
        end
        if (raw_len > ITEM_BYTES) raw_len = ITEM_BYTES;
        len   = OFF_W'(raw_len);
        wr_ok = key.wr_open && present && !fixed;
    end
endmodule

// File: rtl/cfgk_offset.sv
module cfgk_offset #(
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [3:0]       step,
    output logic [OFF_W-1:0] off
);
    logic [OFF_W:0] sum;

    assign sum = {1'b0, off} + (OFF_W+1)'(step);

    always_ff @(posedge clk) begin
        if (rst || clr)
            off <= '0;
        else if (adv)
            off <= sum[OFF_W] ? '1 : sum[OFF_W-1:0];
    end
endmodule

// File: rtl/cfgk_store.sv
module cfgk_store
    import cfgk_pkg::*;
#(
    parameter int         SLOTS       = 6,
    parameter int         ITEM_BYTES  = 16,
    parameter int         SLOT_W      = 3,
    parameter int         OFF_W       = 6,
    parameter logic [7:0] SEED        = 8'h5A,
    parameter logic       DMA_PRESENT = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SLOT_W-1:0]   slot,
    input  logic [OFF_W-1:0]    len,
    input  logic [OFF_W-1:0]    off,
    input  logic [3:0]          nbytes,
    input  logic                we,
    input  logic [LANES*8-1:0]  wdata,
    output logic [LANES*8-1:0]  rdata
);
    localparam int BYTE_W = (ITEM_BYTES > 1) ? $clog2(ITEM_BYTES) : 1;

    logic [SLOTS-1:0][ITEM_BYTES-1:0][7:0] mem;
    logic [LANES-1:0]                      hit;
    logic [LANES-1:0][BYTE_W-1:0]          pos_idx;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic [OFF_W:0] pos;
            assign pos          = {1'b0, off} + (OFF_W+1)'(k);
            assign hit[k]       = (4'(k) < nbytes) && (pos < {1'b0, len});
            assign pos_idx[k]   = pos[BYTE_W-1:0];
            assign rdata[k*8 +: 8] = hit[k] ? mem[slot][pos_idx[k]] : 8'h00;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SLOTS; s++)
                for (int b = 0; b < ITEM_BYTES; b++)
                    mem[s][b] <= (s < FIXED_ITEMS) ? fixed_byte(s, b, DMA_PRESENT)
                                                   : fill_byte(SEED, s, b, ITEM_BYTES);
        end else if (we) begin
            for (int k = 0; k < LANES; k++)
                if (hit[k]) mem[slot][pos_idx[k]] <= wdata[k*8 +: 8];
        end
    end

    // R7: with the write gate closed nothing in storage moves
    assert_locked_store_R7: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem));

    // R9 and R10: signature and feature slots never change after reset
    assert_fixed_items_R9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mem[FIXED_ITEMS-1:0]));
endmodule

// File: rtl/cfgkey_port.sv
module cfgkey_port
    import cfgk_pkg::*;
#(
    parameter int         N_GEN       = 4,
    parameter int         N_ARCH      = 2,
    parameter int         ITEM_BYTES  = 16,
    parameter logic [(N_GEN+N_ARCH)*8-1:0] ITEM_LEN = 48'h00_07_05_10_04_04,
    parameter logic [7:0] SEED        = 8'h5A,
    parameter logic       DMA_PRESENT = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_size,
    input  logic [63:0] bus_wdata,
    output logic [63:0] bus_rdata
);
    localparam int SLOTS   = N_GEN + N_ARCH;
    localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int OFF_W   = $clog2(ITEM_BYTES) + 2;
    localparam int OFF_MAX = (1 << OFF_W) - 1;

    sel_key_t          sel_q;
    logic [OFF_W-1:0]  off_q;
    logic [SLOT_W-1:0] slot;
    logic [OFF_W-1:0]  len;
    logic              wr_ok;
    logic [3:0]        nbytes;
    logic [63:0]       lane_data;
    logic              sel_wr, dat_wr, dat_rd, sel_rd;

    assign nbytes = size_bytes(acc_size_e'(bus_size));
    assign sel_wr = bus_wr && !bus_addr;
    assign dat_wr = bus_wr && bus_addr;
    assign dat_rd = bus_rd && bus_addr && !bus_wr;
    assign sel_rd = bus_rd && !bus_addr && !bus_wr;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (sel_wr)
            sel_q <= sel_key_t'(bus_wdata[15:0]);
    end

    cfgk_keydec #(
        .N_GEN(N_GEN), .N_ARCH(N_ARCH), .ITEM_BYTES(ITEM_BYTES),
        .SLOTS(SLOTS), .SLOT_W(SLOT_W), .OFF_W(OFF_W), .ITEM_LEN(ITEM_LEN)
    ) u_dec (
        .key(sel_q), .slot(slot), .len(len), .wr_ok(wr_ok)
    );

    cfgk_offset #(.OFF_W(OFF_W)) u_off (
        .clk(clk), .rst(rst), .clr(sel_wr), .adv(dat_wr || dat_rd),
        .step(nbytes), .off(off_q)
    );

    cfgk_store #(
        .SLOTS(SLOTS), .ITEM_BYTES(ITEM_BYTES), .SLOT_W(SLOT_W), .OFF_W(OFF_W),
        .SEED(SEED), .DMA_PRESENT(DMA_PRESENT)
    ) u_store (
        .clk(clk), .rst(rst), .slot(slot), .len(len), .off(off_q),
        .nbytes(nbytes), .we(dat_wr && wr_ok), .wdata(bus_wdata), .rdata(lane_data)
    );

    assign bus_rdata = dat_rd ? lane_data : '0;

    // R2: key write resets the cursor and loads the key
    assert_sel_resets_cursor_R2: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> (off_q == '0) && (sel_q == $past(bus_wdata[15:0])));

    // R3: lanes above the access width stay zero
    assert_upper_lanes_zero_R3: assert property (@(posedge clk) disable iff (rst)
        dat_rd |-> ((bus_rdata >> {nbytes, 3'b000}) == '0));

    // R4: each data access steps the cursor by its width
    assert_cursor_step_R4: assert property (@(posedge clk) disable iff (rst)
        ((dat_rd || dat_wr) && (int'(off_q) <= OFF_MAX - LANES))
        |=> off_q == $past(off_q) + OFF_W'($past(nbytes)));

    // R5: cursor at or past the item length yields zero data
    assert_past_end_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && (off_q >= len)) |-> bus_rdata == '0);

    // R11: a read of the selector address returns zero and leaves the cursor alone
    assert_selector_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
        sel_rd |-> bus_rdata == '0);
    assert_selector_read_keeps_cursor_R11: assert property (@(posedge clk) disable iff (rst)
        sel_rd |=> $stable(off_q));
endmodule

// File: tb/cfgkey_port_test.sv
`timescale 1ns/1ps
module cfgkey_port_test;
    localparam logic [1:0] OP_SEL = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_RSEL = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  sz;
        logic [63:0] val;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 49;
    localparam vec_t VECS [NV] = '{
        '{OP_SEL, 2'd0, 64'h0000, 8'd2},                 // R2 select signature
        '{OP_RD,  2'd2, 64'h4B474643, 8'd9},             // R9 signature word
        '{OP_RD,  2'd0, 64'h0, 8'd5},                    // R5 past end
        '{OP_SEL, 2'd0, 64'h0000, 8'd2},                 // R2 reselect rewinds
        '{OP_RD,  2'd0, 64'h43, 8'd3},                   // R3 single byte
        '{OP_RD,  2'd1, 64'h4746, 8'd4},                 // R4 cursor stepped by 1
        '{OP_RD,  2'd0, 64'h4B, 8'd4},                   // R4 cursor stepped by 2
        '{OP_SEL, 2'd0, 64'h0001, 8'd10},
        '{OP_RD,  2'd2, 64'h3, 8'd10},                   // R10 feature word
        '{OP_SEL, 2'd0, 64'h0002, 8'd12},
        '{OP_RD,  2'd3, 64'h7D7C7F7E79787B7A, 8'd12},    // R12 pattern
        '{OP_RD,  2'd3, 64'h7574777671707372, 8'd4},     // R4
        '{OP_RD,  2'd0, 64'h0, 8'd5},                    // R5
        '{OP_SEL, 2'd0, 64'h0003, 8'd12},
        '{OP_RD,  2'd2, 64'h69686B6A, 8'd12},            // R12 short item
        '{OP_RD,  2'd2, 64'h6E, 8'd5},                   // R5 crossing read
        '{OP_RD,  2'd1, 64'h0, 8'd5},
        '{OP_SEL, 2'd0, 64'h8000, 8'd6},
        '{OP_RD,  2'd3, 64'h001C1F1E19181B1A, 8'd6},     // R6 arch slot
        '{OP_SEL, 2'd0, 64'h8001, 8'd6},
        '{OP_RD,  2'd0, 64'h0, 8'd6},                    // R6 zero-length item
        '{OP_SEL, 2'd0, 64'h8002, 8'd6},
        '{OP_RD,  2'd3, 64'h0, 8'd6},                    // R6 unpopulated arch
        '{OP_SEL, 2'd0, 64'h0005, 8'd6},
        '{OP_RD,  2'd2, 64'h0, 8'd6},                    // R6 unpopulated generic
        '{OP_SEL, 2'd0, 64'h0003, 8'd7},
        '{OP_WR,  2'd2, 64'hAABBCCDD, 8'd7},             // R7 gated write
        '{OP_SEL, 2'd0, 64'h0003, 8'd7},
        '{OP_RD,  2'd2, 64'h69686B6A, 8'd7},             // R7 unchanged
        '{OP_SEL, 2'd0, 64'h4003, 8'd8},
        '{OP_WR,  2'd1, 64'h1122, 8'd8},                 // R8 open write
        '{OP_WR,  2'd3, 64'hF0E0D0C0B0A09080, 8'd8},     // R8 clipped at length
        '{OP_SEL, 2'd0, 64'h0003, 8'd8},
        '{OP_RD,  2'd3, 64'h000000A090801122, 8'd8},     // R8 result
        '{OP_SEL, 2'd0, 64'h4000, 8'd9},
        '{OP_WR,  2'd2, 64'hFFFFFFFF, 8'd9},             // R9 write attempt
        '{OP_SEL, 2'd0, 64'h0000, 8'd9},
        '{OP_RD,  2'd2, 64'h4B474643, 8'd9},             // R9 intact
        '{OP_SEL, 2'd0, 64'hC000, 8'd8},
        '{OP_WR,  2'd0, 64'h55, 8'd8},                   // R8 arch write
        '{OP_SEL, 2'd0, 64'h8000, 8'd8},
        '{OP_RD,  2'd1, 64'h1B55, 8'd8},
        '{OP_SEL, 2'd0, 64'h0002, 8'd11},
        '{OP_RSEL,2'd3, 64'h0, 8'd11},                   // R11 selector read
        '{OP_RD,  2'd0, 64'h7A, 8'd11},                  // R11 cursor kept
        '{OP_SEL, 2'd0, 64'h4001, 8'd10},
        '{OP_WR,  2'd2, 64'h0, 8'd10},                   // R10 write attempt
        '{OP_SEL, 2'd0, 64'h0001, 8'd10},
        '{OP_RD,  2'd2, 64'h3, 8'd10}                    // R10 intact
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_addr, bus_wr, bus_rd;
    logic [1:0]  bus_size;
    logic [63:0] bus_wdata;
    logic [63:0] bus_rdata;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    cfgkey_port #(.DMA_PRESENT(1'b1)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input logic [63:0] got, input logic [63:0] exp,
                         input int req, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_addr = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_size = 2'd0; bus_wdata = '0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [1:0] sz,
                          input logic [63:0] val, output logic [63:0] got);
        @(negedge clk);
        bus_addr  = (op == OP_RD || op == OP_WR);
        bus_wr    = (op == OP_SEL || op == OP_WR);
        bus_rd    = (op == OP_RD || op == OP_RSEL);
        bus_size  = sz;
        bus_wdata = bus_wr ? val : 64'h0;
        #1 got = bus_rdata;
        @(posedge clk);
    endtask

    initial begin
        logic [63:0] got;
        rst = 1'b1;
        bus_addr = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_size = 2'd0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1 check(bus_rdata, 64'h0, 3, "R3 idle output zero after reset");

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].op, VECS[i].sz, VECS[i].val, got);
            if (VECS[i].op == OP_RD || VECS[i].op == OP_RSEL)
                check(got, VECS[i].val, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R4 / R5: cursor saturation must not wrap back into the data
        run_op(OP_SEL, 2'd0, 64'h0002, got);
        for (int n = 0; n < 9; n++) begin
            run_op(OP_RD, 2'd3, 64'h0, got);
            if (n == 1) check(got, 64'h7574777671707372, 4, "R4 second 8-byte read");
            if (n >= 2) check(got, 64'h0, 5, $sformatf("R5 saturated read %0d", n));
        end

        // R1: reset restores key 0, cursor 0 and the original contents
        @(negedge clk) rst = 1'b1;
        bus_wr = 1'b0; bus_rd = 1'b0;
        @(posedge clk);
        @(negedge clk) rst = 1'b0;
        run_op(OP_RD, 2'd2, 64'h0, got);
        check(got, 64'h4B474643, 1, "R1 signature without selector write");
        run_op(OP_SEL, 2'd0, 64'h0003, got);
        run_op(OP_RD, 2'd2, 64'h69686B6A, got);
        check(got, 64'h69686B6A, 1, "R1 written item restored");
        run_op(OP_SEL, 2'd0, 64'h8000, got);
        run_op(OP_RD, 2'd1, 64'h0, got);
        check(got, 64'h1B1A, 1, "R1 arch item restored");
        idle();

        $display("test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL all requirements: watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule